// File: doc/BRIEF.md
# I2C Single-Master Byte Engine with Bus Recovery

This block is the bit-level engine of an I2C master. It drives the clock and data wires of an open-drain bus and runs one bus operation per command. The operations are a START condition, a STOP condition, a byte write that returns the acknowledge the slave gave, and a byte read that ends with an acknowledge level the caller picks. A recovery command frees a slave that is holding the data wire low after an interrupted transfer. It sends nine clock pulses with data released and then a STOP.

Each bit slot is four equal quarter phases. One quarter lasts `divQuarter + 1` clocks of the system clock, so one SCL period is four quarters. Data changes only in the first quarter, while SCL is low. SCL is released for the second and third quarters, and the data wire is sampled at the boundary between them, which is the middle of the high phase. The engine drives each wire through an output enable. An enable of 1 pulls the wire low and an enable of 0 releases it. The data wire level is read back through `sdaIn`. A higher layer supplies the sequence of commands for a transaction.

Top module: `i2cm_engine`

## Requirements
- R1: After reset both wires are released (`sclOe`=0, `sdaOe`=0), `cmdReady`=1, `done`=0, `rxByte`=0 and `ackSeen`=1.
- R2: `cmdReady` is 1 only while the engine is idle. A command is taken on a clock edge where `cmdValid` and `cmdReady` are both 1. Its completion gives a `done` pulse one cycle wide, and `cmdReady` is 1 again in that same cycle.
- R3: A command of N bit slots that is accepted at clock edge k raises `done` right after edge k + 4·N·(divQuarter+1). N is 1 for START and STOP, 9 for write and read, and 10 for recovery. `divQuarter` is latched when the command is accepted.
- R4: START (`cmdOp`=2) pulls SDA from high to low while SCL is high, and leaves both wires driven low.
- R5: STOP (`cmdOp`=3) releases SDA from low to high while SCL is high, and leaves both wires released.
- R6: Write (`cmdOp`=4) places the 8 bits of `txByte` on SDA most significant bit first, one per SCL pulse, and changes SDA only while SCL is low. It releases SDA for a ninth pulse and stores the level sampled there in `ackSeen` (0 = acknowledged, 1 = not acknowledged).
- R7: Read (`cmdOp`=5) releases SDA for 8 pulses and samples it in the middle of each high phase, most significant bit first, into `rxByte`. On a ninth pulse it drives `ackLevel` (0 pulls SDA low as ACK, 1 releases it as NACK). The level on the ninth pulse is reported in `ackSeen`.
- R8: Recovery (`cmdOp`=1) gives exactly 9 SCL pulses with SDA released, followed by a STOP, and leaves both wires released.
- R9: Any other `cmdOp` value is accepted and gives `done` in the cycle after acceptance. The wires do not move, and `rxByte` and `ackSeen` keep their values.
- R10: After a write, `rxByte` holds the 8 SDA levels sampled during the data pulses. With no other driver on the bus this equals `txByte`. Only write and read change `rxByte`.
- R11: Output enables are open-drain: 1 pulls a wire low and 0 releases it. A released SDA lets a slave's level be read through `sdaIn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| divQuarter | input | DIV_W | Quarter-phase length minus one, in clocks |
| cmdValid | input | 1 | Command request |
| cmdReady | output | 1 | Engine idle, command can be taken |
| cmdOp | input | 3 | 1 recover, 2 START, 3 STOP, 4 write, 5 read |
| txByte | input | NBITS | Byte to send on a write |
| ackLevel | input | 1 | Acknowledge level to drive after a read |
| done | output | 1 | One-cycle completion pulse |
| rxByte | output | NBITS | Byte sampled by the last read or write |
| ackSeen | output | 1 | Level sampled on the ninth pulse |
| sclOe | output | 1 | SCL pull-low enable |
| sdaOe | output | 1 | SDA pull-low enable |
| sdaIn | input | 1 | SDA wire level |

## Verification
The bench models pull-ups and a slave that changes SDA on each SCL falling edge. The slave presents a scripted level for each slot. Writes are tried with bytes of both alternating and clustered bit patterns, paired with an acknowledging slave and a refusing one, so that bit order and the acknowledge level are each seen on their own. Reads use slave bytes whose high and low halves differ and end with ACK or NACK. This shows the sampled order and the driven ninth level, and that a released line passes the slave's level through. START, STOP and recovery are checked by counting SCL rises and SDA edges during SCL high. Completion times at several divider values separate quarter-length errors from slot-count errors.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam logic [2:0] OP_RECOVER = 3'd1;
  localparam logic [2:0] OP_START   = 3'd2;
  localparam logic [2:0] OP_STOP    = 3'd3;
  localparam logic [2:0] OP_WRITE   = 3'd4;
  localparam logic [2:0] OP_READ    = 3'd5;

  // what one bit slot does with the two wires
  typedef enum logic [2:0] {
    K_START,
    K_STOP,
    K_ONE,
    K_TX,
    K_ACK
  } kind_e;

  typedef struct packed {
    logic load;       // capture txByte into the shifter
    logic shiftIn;    // shift the sampled SDA level in
    logic ackCap;     // store the ninth-pulse level
    logic finish;     // command complete
    logic publish;    // copy the shifter to rxByte
    logic lineUpd;    // update the SCL level
    logic sclHigh;
    logic sdaUpd;     // update the SDA level
    logic sdaHigh;
    logic sdaEdgeOk;  // SDA may move while SCL is high
  } strobe_t;

  function automatic logic isEdgeKind(input kind_e k);
    return (k == K_START) || (k == K_STOP);
  endfunction

  function automatic logic sclLevel(input kind_e k, input logic [1:0] q);
    if (k == K_STOP) return q != 2'd0;
    return (q == 2'd1) || (q == 2'd2);
  endfunction

  function automatic logic sdaLevel(input kind_e k, input logic [1:0] q,
                                    input logic msb, input logic ack);
    case (k)
      K_START: return q < 2'd2;
      K_STOP:  return q >= 2'd2;
      K_TX:    return msb;
      K_ACK:   return ack;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             run,
  input  logic [DIV_W-1:0] divQuarter,
  output logic             tick
);

  logic [DIV_W-1:0] cntQ;
  logic [DIV_W-1:0] divQ;

  assign tick = run && (cntQ == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
      divQ <= '0;
    end else if (restart) begin
      cntQ <= divQuarter;
      divQ <= divQuarter;
    end else if (run) begin
      cntQ <= (cntQ == '0) ? divQ : cntQ - 1'b1;
    end
  end

  // R3: a quarter longer than one clock never ticks twice in a row
  a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rstN)
    (tick && divQ != '0) |=> !tick);

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  input  logic       txFirst,
  input  logic       ackLevel,
  input  logic       txMsb,
  input  logic       tick,
  output logic       cmdReady,
  output logic       run,
  output logic       restart,
  output strobe_t    st
);

  localparam int RECOVER_PULSES = NBITS + 1;
  localparam int SLOT_W = $clog2(RECOVER_PULSES + 2);
  typedef logic [SLOT_W-1:0] slot_t;

  typedef enum logic {S_IDLE, S_RUN} state_e;

  state_e     stateQ;
  logic [2:0] opQ;
  logic       ackQ;
  slot_t      slotQ;
  logic [1:0] qtrQ;

  function automatic logic legalOp(input logic [2:0] op);
    return (op >= OP_RECOVER) && (op <= OP_READ);
  endfunction

  function automatic logic byteOp(input logic [2:0] op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

  function automatic slot_t lastSlot(input logic [2:0] op);
    case (op)
      OP_RECOVER:        return slot_t'(RECOVER_PULSES);
      OP_WRITE, OP_READ: return slot_t'(NBITS);
      default:           return '0;
    endcase
  endfunction

  function automatic kind_e kindOf(input logic [2:0] op, input slot_t s);
    case (op)
      OP_RECOVER: return (s == slot_t'(RECOVER_PULSES)) ? K_STOP : K_ONE;
      OP_START:   return K_START;
      OP_WRITE:   return (s == slot_t'(NBITS)) ? K_ONE : K_TX;
      OP_READ:    return (s == slot_t'(NBITS)) ? K_ACK : K_ONE;
      default:    return K_STOP;
    endcase
  endfunction

  logic       accept;
  logic       atEnd;
  logic [1:0] nxtQtr;
  slot_t      nxtSlot;
  kind_e      curKind;
  kind_e      nxtKind;
  kind_e      firstKind;

  assign cmdReady  = (stateQ == S_IDLE);
  assign run       = (stateQ == S_RUN);
  assign accept    = cmdValid && cmdReady;
  assign restart   = accept && legalOp(cmdOp);
  assign atEnd     = (qtrQ == 2'd3) && (slotQ == lastSlot(opQ));
  assign nxtQtr    = qtrQ + 2'd1;
  assign nxtSlot   = (qtrQ == 2'd3) ? slotQ + 1'b1 : slotQ;
  assign curKind   = kindOf(opQ, slotQ);
  assign nxtKind   = kindOf(opQ, nxtSlot);
  assign firstKind = kindOf(cmdOp, '0);

  always_comb begin
    st = '0;
    if (accept) begin
      if (legalOp(cmdOp)) begin
        st.load      = 1'b1;
        st.lineUpd   = 1'b1;
        st.sclHigh   = sclLevel(firstKind, 2'd0);
        st.sdaUpd    = 1'b1;
        st.sdaHigh   = sdaLevel(firstKind, 2'd0, txFirst, ackLevel);
        st.sdaEdgeOk = isEdgeKind(firstKind);
      end else begin
        st.finish = 1'b1;
      end
    end else if (run && tick) begin
      if (atEnd) begin
        st.finish  = 1'b1;
        st.publish = byteOp(opQ);
      end else begin
        st.lineUpd   = 1'b1;
        st.sclHigh   = sclLevel(nxtKind, nxtQtr);
        st.sdaUpd    = isEdgeKind(nxtKind) || (nxtQtr == 2'd0);
        st.sdaHigh   = sdaLevel(nxtKind, nxtQtr, txMsb, ackQ);
        st.sdaEdgeOk = isEdgeKind(nxtKind);
      end
      // sample at the middle of the SCL high phase
      if (qtrQ == 2'd1 && !isEdgeKind(curKind) && byteOp(opQ)) begin
        if (slotQ < slot_t'(NBITS)) st.shiftIn = 1'b1;
        else                        st.ackCap  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      opQ    <= '0;
      ackQ   <= 1'b1;
      slotQ  <= '0;
      qtrQ   <= '0;
    end else if (restart) begin
      stateQ <= S_RUN;
      opQ    <= cmdOp;
      ackQ   <= ackLevel;
      slotQ  <= '0;
      qtrQ   <= '0;
    end else if (run && tick) begin
      if (atEnd) stateQ <= S_IDLE;
      qtrQ  <= nxtQtr;
      slotQ <= nxtSlot;
    end
  end

  // R9: an undefined opcode never starts bus activity
  a_r9_illegal_idle: assert property (@(posedge clk) disable iff (!rstN)
    (accept && !legalOp(cmdOp)) |=> (stateQ == S_IDLE));

endmodule

// File: rtl/i2cm_dpath.sv
module i2cm_dpath
  import i2cm_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          st,
  input  logic [NBITS-1:0] txByte,
  input  logic             sdaIn,
  output logic             txMsb,
  output logic             sclOe,
  output logic             sdaOe,
  output logic [NBITS-1:0] rxByte,
  output logic             ackSeen,
  output logic             done
);

  logic [NBITS-1:0] shiftQ;

  assign txMsb = shiftQ[NBITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ  <= '0;
      sclOe   <= 1'b0;
      sdaOe   <= 1'b0;
      rxByte  <= '0;
      ackSeen <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= st.finish;
      if (st.load)         shiftQ  <= txByte;
      else if (st.shiftIn) shiftQ  <= {shiftQ[NBITS-2:0], sdaIn};
      if (st.ackCap)       ackSeen <= sdaIn;
      if (st.publish)      rxByte  <= shiftQ;
      if (st.lineUpd)      sclOe   <= !st.sclHigh;
      if (st.sdaUpd)       sdaOe   <= !st.sdaHigh;
    end
  end

  // R6: with SCL released, SDA moves only for a START or STOP
  a_r6_sda_steady: assert property (@(posedge clk) disable iff (!rstN)
    ((sdaOe != $past(sdaOe)) && !sclOe && !$past(sclOe)) |-> $past(st.sdaEdgeOk));

  // R10: rxByte changes only when a byte command publishes
  a_r10_rx_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.publish) |-> (rxByte == $past(rxByte)));

  // R9: ackSeen changes only on a ninth-pulse capture
  a_r9_ack_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$past(st.ackCap) |-> (ackSeen == $past(ackSeen)));

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divQuarter,
  input  logic             cmdValid,
  output logic             cmdReady,
  input  logic [2:0]       cmdOp,
  input  logic [NBITS-1:0] txByte,
  input  logic             ackLevel,
  output logic             done,
  output logic [NBITS-1:0] rxByte,
  output logic             ackSeen,
  output logic             sclOe,
  output logic             sdaOe,
  input  logic             sdaIn
);

  strobe_t st;
  logic    tick;
  logic    run;
  logic    restart;
  logic    txMsb;

  i2cm_tick #(.DIV_W(DIV_W)) uTick (
    .clk(clk), .rstN(rstN), .restart(restart), .run(run),
    .divQuarter(divQuarter), .tick(tick)
  );

  i2cm_ctrl #(.NBITS(NBITS)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .txFirst(txByte[NBITS-1]), .ackLevel(ackLevel), .txMsb(txMsb),
    .tick(tick), .cmdReady(cmdReady), .run(run), .restart(restart), .st(st)
  );

  i2cm_dpath #(.NBITS(NBITS)) uDpath (
    .clk(clk), .rstN(rstN), .st(st), .txByte(txByte), .sdaIn(sdaIn),
    .txMsb(txMsb), .sclOe(sclOe), .sdaOe(sdaOe), .rxByte(rxByte),
    .ackSeen(ackSeen), .done(done)
  );

  // R2: completion always coincides with the engine being free again
  a_r2_done_ready: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cmdReady);

endmodule

// File: tb/tb_i2cm_engine.sv
`timescale 1ns/100ps
module tb_i2cm_engine;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divQ = 16'd2;
  logic        cmdValid = 1'b0;
  logic        cmdReady;
  logic [2:0]  cmdOp = 3'd0;
  logic [7:0]  txByte = 8'h00;
  logic        ackLevel = 1'b0;
  logic        done;
  logic [7:0]  rxByte;
  logic        ackSeen;
  logic        sclOe, sdaOe;
  logic        sclIn, sdaIn, slvRel;

  always #2.5 clk = ~clk;

  i2cm_engine dut (
    .clk(clk), .rstN(rstN), .divQuarter(divQ), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .txByte(txByte), .ackLevel(ackLevel),
    .done(done), .rxByte(rxByte), .ackSeen(ackSeen), .sclOe(sclOe),
    .sdaOe(sdaOe), .sdaIn(sdaIn)
  );

  // pull-ups and slave model
  int         totalFalls = 0, rises = 0, starts = 0, stops = 0, baseFalls = 0;
  logic [15:0] busBits = '0;
  logic [8:0]  slvPat = 9'h1FF;
  logic        prevScl = 1'b1, prevSda = 1'b1;
  int          slvIdx;

  assign sclIn  = ~sclOe;
  assign slvIdx = totalFalls - baseFalls;
  assign slvRel = (slvIdx >= 0 && slvIdx <= 8) ? slvPat[8 - slvIdx] : 1'b1;
  assign sdaIn  = ~sdaOe & slvRel;

  always @(negedge clk) begin
    if (prevScl && !sclIn) totalFalls <= totalFalls + 1;
    if (!prevScl && sclIn) begin
      rises   <= rises + 1;
      busBits <= {busBits[14:0], sdaIn};
    end
    if (prevScl && sclIn && prevSda && !sdaIn) starts <= starts + 1;
    if (prevScl && sclIn && !prevSda && sdaIn) stops <= stops + 1;
    prevScl <= sclIn;
    prevSda <= sdaIn;
  end

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int slotsOf(input logic [2:0] op);
    case (op)
      3'd1: return 10;
      3'd2, 3'd3: return 1;
      3'd4, 3'd5: return 9;
      default: return 0;
    endcase
  endfunction

  task automatic runCmd(input logic [2:0] op, input logic [7:0] tx,
                        input logic al, input logic [8:0] pat, output int cyc);
    @(posedge clk); #1;
    slvPat    = pat;
    baseFalls = totalFalls;
    cmdOp     = op;
    txByte    = tx;
    ackLevel  = al;
    cmdValid  = 1'b1;
    @(posedge clk); #1;
    cmdValid = 1'b0;
    cyc = 0;
    if (!done) chk(cmdReady == 1'b0, "R2", "ready while busy", cmdReady, 0);
    while (!done && cyc < 50000) begin
      @(posedge clk); #1;
      cyc++;
    end
    @(posedge clk); #1;
    chk(done == 1'b0 && cmdReady == 1'b1, "R2", "done single pulse",
        {done, cmdReady}, 2'b01);
    #0;
  endtask

  // R1..R8, R10, R11 vectors: op, txByte, ackLevel, slave byte, slave ack
  localparam logic [20:0] VEC [0:7] = '{
    {3'd2, 8'h00, 1'b0, 8'h00, 1'b0},
    {3'd4, 8'hA5, 1'b0, 8'h00, 1'b0},
    {3'd4, 8'h3C, 1'b0, 8'h00, 1'b1},
    {3'd2, 8'h00, 1'b0, 8'h00, 1'b0},
    {3'd5, 8'h00, 1'b0, 8'h96, 1'b0},
    {3'd5, 8'h00, 1'b1, 8'h5A, 1'b0},
    {3'd3, 8'h00, 1'b0, 8'h00, 1'b0},
    {3'd1, 8'h00, 1'b0, 8'h00, 1'b0}
  };

  logic [7:0] expRx = 8'h00;
  logic       expAck = 1'b1;

  task automatic doOp(input logic [2:0] op, input logic [7:0] tx, input logic al,
                      input logic [7:0] slvByte, input logic slvAck);
    int cyc, r0, s0, p0, expCyc;
    logic [8:0] pat;
    pat = (op == 3'd4) ? {8'hFF, slvAck} : (op == 3'd5) ? {slvByte, 1'b1} : 9'h1FF;
    r0 = rises; s0 = starts; p0 = stops;
    runCmd(op, tx, al, pat, cyc);
    expCyc = 4 * slotsOf(op) * (int'(divQ) + 1);
    chk(cyc == expCyc, "R3", "cycles to done", cyc, expCyc);
    case (op)
      3'd2: begin
        chk(starts - s0 == 1 && stops == p0, "R4", "start edges", starts - s0, 1);
        chk(sclOe && sdaOe, "R4", "lines after start", {sclOe, sdaOe}, 2'b11);
      end
      3'd3: begin
        chk(stops - p0 == 1 && starts == s0, "R5", "stop edges", stops - p0, 1);
        chk(!sclOe && !sdaOe, "R5", "lines after stop", {sclOe, sdaOe}, 2'b00);
      end
      3'd4: begin
        expRx = tx; expAck = slvAck;
        chk(rises - r0 == 9, "R6", "write pulses", rises - r0, 9);
        chk(busBits[8:0] == {tx, slvAck}, "R6", "write bits on bus",
            busBits[8:0], {tx, slvAck});
        chk(starts == s0 && stops == p0, "R6", "sda moved with scl high",
            starts - s0 + stops - p0, 0);
        chk(ackSeen == expAck, "R6", "ack sampled", ackSeen, expAck);
        chk(rxByte == expRx, "R10", "write readback", rxByte, expRx);
      end
      3'd5: begin
        expRx = slvByte; expAck = al;
        chk(rises - r0 == 9, "R7", "read pulses", rises - r0, 9);
        chk(rxByte == expRx, "R7 R11", "read byte", rxByte, expRx);
        chk(busBits[0] == al, "R7", "ack level on bus", busBits[0], al);
        chk(ackSeen == expAck, "R7", "ack reported", ackSeen, expAck);
        chk(starts == s0 && stops == p0, "R7", "sda moved with scl high",
            starts - s0 + stops - p0, 0);
      end
      3'd1: begin
        chk(rises - r0 == 10, "R8", "recovery pulses", rises - r0, 10);
        chk(busBits[9:0] == 10'h3FE, "R8", "sda during pulses", busBits[9:0], 10'h3FE);
        chk(stops - p0 == 1 && starts == s0, "R8", "final stop", stops - p0, 1);
        chk(!sclOe && !sdaOe, "R8", "lines after recovery", {sclOe, sdaOe}, 2'b00);
      end
      default: ;
    endcase
    chk(rxByte == expRx && ackSeen == expAck, "R10", "result registers",
        {rxByte, ackSeen}, {expRx, expAck});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int cyc;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk(sclOe == 1'b0 && sdaOe == 1'b0, "R1", "lines in reset", {sclOe, sdaOe}, 0);
    chk(cmdReady && !done, "R1", "ready/done in reset", {cmdReady, done}, 2'b10);
    chk(rxByte == 8'h00 && ackSeen == 1'b1, "R1", "results in reset",
        {rxByte, ackSeen}, 9'h001);
    rstN = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk(sclOe == 1'b0 && sdaOe == 1'b0 && cmdReady, "R1", "idle after reset",
        {sclOe, sdaOe, cmdReady}, 3'b001);

    for (int i = 0; i < 8; i++) begin
      logic [20:0] v;
      v = VEC[i];
      doOp(v[20:18], v[17:10], v[9], v[8:1], v[0]);
    end

    // R3 fastest divider, R6 another write pattern
    divQ = 16'd0;
    doOp(3'd2, 8'h00, 1'b0, 8'h00, 1'b0);
    doOp(3'd4, 8'h81, 1'b0, 8'h00, 1'b0);
    doOp(3'd3, 8'h00, 1'b0, 8'h00, 1'b0);

    // R9 undefined opcodes
    for (int op = 6; op < 9; op++) begin
      logic [2:0] o;
      int r0;
      o = (op == 8) ? 3'd0 : 3'(op);
      r0 = rises;
      runCmd(o, 8'hFF, 1'b1, 9'h1FF, cyc);
      chk(cyc == 0, "R9", "undefined op done delay", cyc, 0);
      chk(rises == r0 && !sclOe && !sdaOe, "R9", "no bus activity",
          rises - r0, 0);
      chk(rxByte == expRx && ackSeen == expAck, "R9", "results kept",
          {rxByte, ackSeen}, {expRx, expAck});
    end

    // R8 recovery at another divider, R3 timing
    divQ = 16'd1;
    doOp(3'd1, 8'h00, 1'b0, 8'h00, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule